// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is one storage cell of a programmable logic fabric. A set of static configuration inputs turns it into a combinational pass-through, an edge-triggered D flop, a toggle flop or a level-sensitive D latch. Its clock is picked per cell from a group of fabric-wide clocks or from a locally generated term clock. The picked clock can be inverted, and in the flop modes the cell can capture on both edges.

The value stored comes either from the logic-array sum or straight from the input pin, so the cell also serves as an input register. Local set and reset terms and a fabric-wide set/reset line act asynchronously. A synchronous clock enable qualifies every capture. A dedicated init pulse loads the cell's configured power-up value and overrides every other control. A second output gives the cell's output enable, either fixed on or taken from a control term. The cell has no streaming data path, so every pin is a plain level signal.

Top module: `mc_cell`

## Requirements
- R1: While `init_i` is 1 the stored value equals `cfg_init_val`, whatever the other inputs do. After release it holds until a capture or an asynchronous force.
- R2: With `cfg_mode` = 0 (combinational) `q_o` follows the selected data without any clock.
- R3: `cfg_clk_sel` values 0 to NUM_GCLK-1 pick the matching bit of `gclk_i`, and the value NUM_GCLK picks `ptclk_i`. Unselected clocks cause no capture.
- R4: With `cfg_clk_inv` = 1 the cell captures on the falling edge of the selected clock instead of the rising edge.
- R5: In toggle mode (`cfg_mode` = 2) the stored value inverts at each active edge while the selected data is 1, and holds while it is 0.
- R6: In latch mode (`cfg_mode` = 3) the output follows the data while the selected clock (after polarity) is high and `ce_i` is 1. Otherwise it holds.
- R7: In D mode (`cfg_mode` = 1) the cell captures the selected data at an active edge. In D and toggle modes nothing is captured while `ce_i` is 0.
- R8: With `cfg_dual_edge` = 1, the D and toggle modes capture on both edges of the selected clock. With it at 0 they capture on one edge only.
- R9: `lrst_i` forces the stored value to 0 and `lset_i` forces it to 1, asynchronously. When both are asserted, reset wins.
- R10: `gsr_i` forces the stored value to `cfg_gsr_set` (1 sets, 0 clears). It combines with the local terms, and a reset from any source still wins.
- R11: `cfg_din_pin` = 1 selects `pin_i` as data, and 0 selects `sum_i`.
- R12: `oe_o` is 1 when `cfg_oe_term` = 0, and equals `oe_term_i` when `cfg_oe_term` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_i | input | NUM_GCLK | fabric-wide clocks |
| ptclk_i | input | 1 | locally formed term clock |
| init_i | input | 1 | power-up load pulse, overrides everything |
| cfg_mode | input | 2 | 0 comb, 1 D flop, 2 toggle flop, 3 latch |
| cfg_clk_sel | input | SEL_W | clock source select |
| cfg_clk_inv | input | 1 | invert selected clock |
| cfg_dual_edge | input | 1 | capture on both edges |
| cfg_init_val | input | 1 | power-up value |
| cfg_gsr_set | input | 1 | global line sets (1) or clears (0) |
| cfg_din_pin | input | 1 | data from pin (1) or sum (0) |
| cfg_oe_term | input | 1 | output enable from control term |
| sum_i | input | 1 | logic-array sum |
| pin_i | input | 1 | direct pin input |
| ce_i | input | 1 | synchronous clock enable |
| lset_i | input | 1 | local asynchronous set |
| lrst_i | input | 1 | local asynchronous reset |
| gsr_i | input | 1 | fabric-wide asynchronous set/reset |
| oe_term_i | input | 1 | output enable control term |
| q_o | output | 1 | cell output |
| oe_o | output | 1 | output enable |

## Verification
The clocked properties sample on the first fabric clock. They assume that configuration changes only while the selected clock is low, so that changing the source or polarity cannot create a false edge. They also assume that asynchronous controls stay stable across each sampling edge. Their toggle and hold checks apply only when that first clock is selected with normal polarity and single-edge capture. The stimulus therefore changes inputs only just after a falling edge of that clock. It keeps the other clocks low whenever it switches source, and it drops the enable before flipping polarity.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MC_COMB  = 2'd0,
    MC_DFF   = 2'd1,
    MC_TFF   = 2'd2,
    MC_LATCH = 2'd3
  } mc_mode_e;
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int NUM_GCLK = 3,
  parameter int SEL_W = $clog2(NUM_GCLK + 1)
) (
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                ptclk_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                inv_i,
  output logic                eclk_o
);
  localparam int NSRC = NUM_GCLK + 1;
  logic [NSRC-1:0] srcs;
  logic            picked;

  assign srcs = {ptclk_i, gclk_i};

  always_comb begin
    picked = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (sel_i == SEL_W'(k)) picked = srcs[k];
    end
  end

  assign eclk_o = picked ^ inv_i;
endmodule

// File: rtl/mc_async_ctl.sv
module mc_async_ctl (
  input  logic init_i,
  input  logic init_val_i,
  input  logic gsr_i,
  input  logic gsr_set_i,
  input  logic lset_i,
  input  logic lrst_i,
  output logic clr_o,
  output logic pre_o
);
  logic rst_any, set_any;

  assign rst_any = lrst_i | (gsr_i & ~gsr_set_i);
  assign set_any = lset_i | (gsr_i & gsr_set_i);

  // init overrides; otherwise reset beats set
  assign clr_o = init_i ? ~init_val_i : rst_any;
  assign pre_o = init_i ?  init_val_i : (~rst_any & set_any);
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic eclk_i,
  input  logic clr_i,
  input  logic pre_i,
  input  logic cap_en_i,
  input  logic dual_i,
  input  logic tgl_i,
  input  logic d_i,
  output logic q_o
);
  logic q_rise, q_fall, nxt;

  assign q_o = q_rise ^ q_fall;
  assign nxt = tgl_i ? (q_o ^ d_i) : d_i;

  always_ff @(posedge eclk_i or posedge clr_i or posedge pre_i) begin
    if (clr_i)         q_rise <= 1'b0;
    else if (pre_i)    q_rise <= 1'b1;
    else if (cap_en_i) q_rise <= nxt ^ q_fall;
  end

  always_ff @(negedge eclk_i or posedge clr_i or posedge pre_i) begin
    if (clr_i || pre_i)          q_fall <= 1'b0;
    else if (cap_en_i && dual_i) q_fall <= nxt ^ q_rise;
  end
endmodule

// File: rtl/mc_latch.sv
module mc_latch (
  input  logic open_i,
  input  logic clr_i,
  input  logic pre_i,
  input  logic d_i,
  output logic q_o
);
  always_latch begin
    if (clr_i)       q_o <= 1'b0;
    else if (pre_i)  q_o <= 1'b1;
    else if (open_i) q_o <= d_i;
  end
endmodule

// File: rtl/mc_cell.sv
module mc_cell #(
  parameter int NUM_GCLK = 3,
  parameter int SEL_W = $clog2(NUM_GCLK + 1)
) (
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                ptclk_i,
  input  logic                init_i,
  input  logic [1:0]          cfg_mode,
  input  logic [SEL_W-1:0]    cfg_clk_sel,
  input  logic                cfg_clk_inv,
  input  logic                cfg_dual_edge,
  input  logic                cfg_init_val,
  input  logic                cfg_gsr_set,
  input  logic                cfg_din_pin,
  input  logic                cfg_oe_term,
  input  logic                sum_i,
  input  logic                pin_i,
  input  logic                ce_i,
  input  logic                lset_i,
  input  logic                lrst_i,
  input  logic                gsr_i,
  input  logic                oe_term_i,
  output logic                q_o,
  output logic                oe_o
);
  import mc_pkg::*;

  mc_mode_e mode;
  logic     eclk, clr, pre, dsel, is_flop, cap_en, gate_open;
  logic     q_flop, q_lat;

  assign mode      = mc_mode_e'(cfg_mode);
  assign dsel      = cfg_din_pin ? pin_i : sum_i;
  assign is_flop   = (mode == MC_DFF) || (mode == MC_TFF);
  assign cap_en    = is_flop & ce_i;
  assign gate_open = (mode == MC_LATCH) & eclk & ce_i;

  mc_clk_sel #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_clk (
    .gclk_i(gclk_i), .ptclk_i(ptclk_i), .sel_i(cfg_clk_sel),
    .inv_i(cfg_clk_inv), .eclk_o(eclk)
  );

  mc_async_ctl u_async (
    .init_i(init_i), .init_val_i(cfg_init_val), .gsr_i(gsr_i),
    .gsr_set_i(cfg_gsr_set), .lset_i(lset_i), .lrst_i(lrst_i),
    .clr_o(clr), .pre_o(pre)
  );

  mc_store u_store (
    .eclk_i(eclk), .clr_i(clr), .pre_i(pre), .cap_en_i(cap_en),
    .dual_i(cfg_dual_edge), .tgl_i(mode == MC_TFF), .d_i(dsel),
    .q_o(q_flop)
  );

  mc_latch u_latch (
    .open_i(gate_open), .clr_i(clr), .pre_i(pre), .d_i(dsel), .q_o(q_lat)
  );

  always_comb begin
    unique case (mode)
      MC_COMB:  q_o = dsel;
      MC_LATCH: q_o = q_lat;
      default:  q_o = q_flop;
    endcase
  end

  assign oe_o = cfg_oe_term ? oe_term_i : 1'b1;
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk (
  input logic       smp_clk,
  input logic       init_i,
  input logic [1:0] cfg_mode,
  input logic       sel_g0,
  input logic       cfg_clk_inv,
  input logic       cfg_dual_edge,
  input logic       cfg_init_val,
  input logic       cfg_gsr_set,
  input logic       lset_i,
  input logic       lrst_i,
  input logic       gsr_i,
  input logic       ce_i,
  input logic       dsel,
  input logic       q_o
);
  import mc_pkg::*;

  logic any_force, plain_clk, stored;
  assign any_force = lset_i | lrst_i | gsr_i;
  assign plain_clk = sel_g0 & ~cfg_clk_inv & ~cfg_dual_edge;
  assign stored    = (cfg_mode != MC_COMB);

  AST_INIT_LOAD: assert property (@(posedge smp_clk) disable iff (init_i)
    ($fell(init_i) && stored && !any_force) |-> (q_o == cfg_init_val)); // R1

  AST_COMB_PASS: assert property (@(posedge smp_clk) disable iff (init_i)
    (cfg_mode == MC_COMB) |-> (q_o == dsel)); // R2

  AST_TOGGLE: assert property (@(posedge smp_clk) disable iff (init_i)
    (cfg_mode == MC_TFF && plain_clk && ce_i && dsel && !any_force)
    |=> (q_o != $past(q_o)) || any_force || !$stable(cfg_mode) || !$stable(plain_clk)); // R5

  AST_CE_HOLD: assert property (@(posedge smp_clk) disable iff (init_i)
    ((cfg_mode == MC_DFF || cfg_mode == MC_TFF) && plain_clk && !ce_i && !any_force)
    |=> $stable(q_o) || any_force || !$stable(cfg_mode) || !$stable(plain_clk)); // R7

  AST_RST_WINS: assert property (@(posedge smp_clk) disable iff (init_i)
    (stored && lrst_i) |-> (q_o == 1'b0)); // R9

  AST_SET_ONE: assert property (@(posedge smp_clk) disable iff (init_i)
    (stored && lset_i && !lrst_i && !gsr_i) |-> (q_o == 1'b1)); // R9

  AST_GSR_DIR: assert property (@(posedge smp_clk) disable iff (init_i)
    (stored && gsr_i && !lset_i && !lrst_i) |-> (q_o == cfg_gsr_set)); // R10
endmodule

bind mc_cell mc_cell_chk u_chk (
  .smp_clk(gclk_i[0]), .init_i(init_i), .cfg_mode(cfg_mode),
  .sel_g0(cfg_clk_sel == '0), .cfg_clk_inv(cfg_clk_inv),
  .cfg_dual_edge(cfg_dual_edge), .cfg_init_val(cfg_init_val),
  .cfg_gsr_set(cfg_gsr_set), .lset_i(lset_i), .lrst_i(lrst_i),
  .gsr_i(gsr_i), .ce_i(ce_i), .dsel(dsel), .q_o(q_o)
);

// File: tb/tb_mc_cell.sv
module tb_mc_cell;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, pt = 1'b0;
  logic init_i = 1'b1;
  logic [1:0] cfg_mode = 2'd1, cfg_clk_sel = 2'd0;
  logic cfg_clk_inv = 0, cfg_dual_edge = 0, cfg_init_val = 1, cfg_gsr_set = 0;
  logic cfg_din_pin = 0, cfg_oe_term = 0;
  logic sum_i = 0, pin_i = 0, ce_i = 0, lset_i = 0, lrst_i = 0, gsr_i = 0, oe_term_i = 0;
  logic q_o, oe_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 c0 = ~c0;

  mc_cell dut (
    .gclk_i({c2, c1, c0}), .ptclk_i(pt), .init_i(init_i), .cfg_mode(cfg_mode),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv),
    .cfg_dual_edge(cfg_dual_edge), .cfg_init_val(cfg_init_val),
    .cfg_gsr_set(cfg_gsr_set), .cfg_din_pin(cfg_din_pin),
    .cfg_oe_term(cfg_oe_term), .sum_i(sum_i), .pin_i(pin_i), .ce_i(ce_i),
    .lset_i(lset_i), .lrst_i(lrst_i), .gsr_i(gsr_i), .oe_term_i(oe_term_i),
    .q_o(q_o), .oe_o(oe_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // {din_pin, sum, pin, ce, expected q}, D mode on clock 0
  localparam logic [4:0] VEC [8] = '{
    5'b01011, 5'b00110, 5'b10111, 5'b10001,
    5'b10010, 5'b01000, 5'b01111, 5'b11010
  };

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset / init behaviour
    repeat (2) @(negedge c0);
    chk("R1 init loads one", q_o, 1'b1);
    init_i = 0;
    @(posedge c0); #2;
    chk("R1 hold after release", q_o, 1'b1);
    @(negedge c0); init_i = 1; cfg_init_val = 0; #1;
    chk("R1 init loads zero", q_o, 1'b0);
    @(negedge c0); init_i = 0;

    // R7 R11 vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge c0);
      {cfg_din_pin, sum_i, pin_i, ce_i} = VEC[i][4:1];
      @(posedge c0); #2;
      chk("R7/R11 table", q_o, VEC[i][0]);
    end

    // R5 toggle mode
    @(negedge c0); cfg_mode = 2'd2; cfg_din_pin = 0; sum_i = 1; ce_i = 1;
    @(posedge c0); #2; chk("R5 toggle to 1", q_o, 1'b1);
    @(posedge c0); #2; chk("R5 toggle to 0", q_o, 1'b0);
    @(negedge c0); sum_i = 0;
    @(posedge c0); #2; chk("R5 hold t=0", q_o, 1'b0);

    // R3 clock select
    @(negedge c0); cfg_mode = 2'd1; cfg_clk_sel = 2'd1; sum_i = 1;
    @(posedge c0); #2; chk("R3 unselected clock ignored", q_o, 1'b0);
    @(negedge c0); c1 = 1; #1; chk("R3 gclk1 capture", q_o, 1'b1);
    c1 = 0;
    @(negedge c0); cfg_clk_sel = 2'd3; sum_i = 0; #1; pt = 1; #1;
    chk("R3 term clock capture", q_o, 1'b0);
    pt = 0;

    // R4 inverted polarity
    @(negedge c0); ce_i = 0; cfg_clk_sel = 2'd2; cfg_clk_inv = 1; #1;
    ce_i = 1; sum_i = 1; #1; c2 = 1; #1;
    chk("R4 no capture on rise", q_o, 1'b0);
    @(negedge c0); c2 = 0; #1;
    chk("R4 capture on fall", q_o, 1'b1);
    @(negedge c0); ce_i = 0; cfg_clk_inv = 0; #1; ce_i = 1;

    // R6 latch
    @(negedge c0); cfg_mode = 2'd3; sum_i = 1; c2 = 1; #1;
    chk("R6 transparent 1", q_o, 1'b1);
    sum_i = 0; #1; chk("R6 transparent 0", q_o, 1'b0);
    sum_i = 1; #1; c2 = 0; #1; sum_i = 0; #1;
    chk("R6 closed holds", q_o, 1'b1);
    @(negedge c0); c2 = 1; ce_i = 0; #1;
    chk("R6 enable qualifies gate", q_o, 1'b1);
    ce_i = 1; #1; chk("R6 reopened", q_o, 1'b0);
    c2 = 0;

    // R8 dual edge
    @(negedge c0); cfg_mode = 2'd1; cfg_dual_edge = 1; sum_i = 1; #1; c2 = 1; #1;
    chk("R8 rise capture", q_o, 1'b1);
    sum_i = 0; #1; c2 = 0; #1;
    chk("R8 fall capture", q_o, 1'b0);
    @(negedge c0); sum_i = 1; #1; c2 = 1; #1; c2 = 0; #1;
    chk("R8 stays on equal data", q_o, 1'b1);
    @(negedge c0); cfg_dual_edge = 0; sum_i = 0; #1; c2 = 1; #1;
    chk("R8 single rise capture", q_o, 1'b0);
    sum_i = 1; #1; c2 = 0; #1;
    chk("R8 no fall capture single", q_o, 1'b0);

    // R9 local async
    @(negedge c0); lrst_i = 1; sum_i = 0; #1; chk("R9 reset", q_o, 1'b0);
    @(negedge c0); lrst_i = 0; lset_i = 1; #1; chk("R9 set", q_o, 1'b1);
    @(negedge c0); lrst_i = 1; #1; chk("R9 reset wins", q_o, 1'b0);
    @(negedge c0); lrst_i = 0; #1; chk("R9 set after reset drop", q_o, 1'b1);
    @(negedge c0); lset_i = 0; #1; chk("R9 hold after release", q_o, 1'b1);

    // R10 global set/reset
    @(negedge c0); cfg_gsr_set = 0; gsr_i = 1; #1; chk("R10 global clears", q_o, 1'b0);
    @(negedge c0); gsr_i = 0; cfg_gsr_set = 1; #1; gsr_i = 1; #1;
    chk("R10 global sets", q_o, 1'b1);
    @(negedge c0); lrst_i = 1; #1; chk("R10 local reset beats global set", q_o, 1'b0);
    @(negedge c0); lrst_i = 0; gsr_i = 0; cfg_gsr_set = 0; #1;
    chk("R10 hold after release", q_o, 1'b0);

    // R2 combinational
    @(negedge c0); cfg_mode = 2'd0; cfg_clk_sel = 2'd0; sum_i = 1; #1;
    chk("R2 comb 1", q_o, 1'b1);
    sum_i = 0; #1; chk("R2 comb 0", q_o, 1'b0);
    cfg_din_pin = 1; pin_i = 1; #1; chk("R2/R11 comb from pin", q_o, 1'b1);

    // R12 output enable
    @(negedge c0); cfg_oe_term = 0; oe_term_i = 0; #1; chk("R12 oe fixed on", oe_o, 1'b1);
    cfg_oe_term = 1; #1; chk("R12 oe term low", oe_o, 1'b0);
    oe_term_i = 1; #1; chk("R12 oe term high", oe_o, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule